// File: doc/BRIEF.md
# GPIO Pad Community Controller

This block owns a small community of general-purpose pads grouped into banks. Every pad has a pair of 32-bit configuration words. The first word sets the value driven onto the pad and returns the synchronised input level. It also selects an input inversion and a receive-event mode, and it keeps a two-bit reset-domain field as plain storage. The second word is plain 32-bit storage for settings this block does not interpret.

Each pad's input passes through a two-flop synchroniser and can be inverted. An event detector then flags a level, a rising edge, either edge, or nothing. Each bank has a write-one-to-clear status register and an enable register, and the enabled pending events of all banks are ORed into one interrupt line.

Software reaches everything through a plain 32-bit word-addressed register port. Every request is accepted in the cycle it is presented, so the port has no back-pressure. Read data returns in the following cycle together with a one-cycle valid strobe. A read-only pointer register gives the byte offset of the first pad entry, so software can locate the pad array.

Top module: `gpio_community`

## Requirements
- R1: A read at offset 0x00C returns PAD_BASE, the byte offset of pad 0's first word. Writes to 0x00C have no effect.
- R2: Pad p's first word sits at PAD_BASE + 16·p. Its bit 0 is stored, read back, and driven on pad_out[p]. All pad_out bits are 0 after reset.
- R3: Bit 1 of a pad's first word reads the pad input after two clock edges of synchronisation, so a read sampled one edge after an input change still shows the old level. Writes to bit 1 are ignored.
- R4: Bits 31:30, bit 23 and bits 26:25 of the first word read back what was last written. All other bits except 0 and 1 read zero.
- R5: The second word at entry offset +4 is full 32-bit read/write storage. Entry offsets +8 and +12 read zero.
- R6: With mode 00 (level), a pad's status bit is set in every cycle in which its effective input (input XOR invert bit 23) is high. A clear issued while that input stays high does not stick.
- R7: With mode 01 (bit 25 only), a rising effective input sets the status bit, which then holds until it is cleared. A falling input sets nothing.
- R8: With mode 11 (bits 26:25 both set), both rising and falling effective inputs set the status bit.
- R9: With mode 10 (bit 26 only), the pad raises no events.
- R10: Bit 23 inverts the input before event detection. With edge mode and inversion, a falling pad input sets status and a rising pad input does not.
- R11: Status for bank n sits at 0x100 + 4·n, where bit i is pad n·PADS_PER_BANK + i. Writing 1 clears a bit. An event arriving in the same cycle as the clear keeps the bit set.
- R12: Enable for bank n sits at 0x120 + 4·n and is read/write, with bits at or above PADS_PER_BANK reading zero. The irq output is the OR over all bits of status AND enable, so it rises on the third clock edge after a pad input change.
- R13: Unmapped offsets, misaligned addresses (bits 1:0 nonzero), offsets of banks that do not exist and offsets past the last pad entry all read zero and ignore writes.
- R14: A read request returns bus_rdata with bus_rvalid high on the cycle after it is accepted. bus_rvalid is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request, always accepted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read |
| pad_in | input | NUM_PADS | Asynchronous pad inputs |
| pad_out | output | NUM_PADS | Pad output drive values |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with two banks of eight pads and PAD_BASE at 0x400. With these values the second bank carries all the event tests, so bank-local bit numbering is exercised away from bit 0. Offset 0x108 falls inside the status window but names a bank that does not exist, and the bits above the eighth in an enable write show the masking. The irq and same-cycle clear checks are timed to the exact clock edge on which the synchroniser and edge history deliver the event.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  // first-word field positions (software-visible)
  localparam int unsigned TX_BIT  = 0;
  localparam int unsigned RX_BIT  = 1;
  localparam int unsigned INV_BIT = 23;
  localparam int unsigned MODE_LO = 25;
  localparam int unsigned RST_LO  = 30;

  // fixed register offsets
  localparam int unsigned PTR_OFF    = 'h00C;
  localparam int unsigned STS_OFF    = 'h100;
  localparam int unsigned ENA_OFF    = 'h120;
  localparam int unsigned PAD_STRIDE = 16;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'b00,
    EV_RISE  = 2'b01,
    EV_OFF   = 2'b10,
    EV_BOTH  = 2'b11
  } ev_mode_e;

  typedef struct packed {
    logic [1:0] rst_cfg;
    ev_mode_e   mode;
    logic       inv;
    logic       tx;
  } pad_cfg_t;
endpackage

// File: rtl/gpc_sync2.sv
module gpc_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpc_pad_cell.sv
module gpc_pad_cell
  import gpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_dw0,
  input  logic        wr_dw1,
  input  logic [31:0] wdata,
  input  logic        rx_sync,
  output logic        tx,
  output logic [31:0] dw0_rd,
  output logic [31:0] dw1_rd,
  output logic        event_o
);
  pad_cfg_t    cfg;
  logic [31:0] dw1_q;
  logic        rx_eff;
  logic        hist_q;

  assign rx_eff = rx_sync ^ cfg.inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      dw1_q  <= '0;
      hist_q <= 1'b0;
    end else begin
      if (wr_dw0) begin
        cfg.tx      <= wdata[TX_BIT];
        cfg.inv     <= wdata[INV_BIT];
        cfg.mode    <= ev_mode_e'(wdata[MODE_LO +: 2]);
        cfg.rst_cfg <= wdata[RST_LO +: 2];
      end
      if (wr_dw1) dw1_q <= wdata;
      hist_q <= rx_eff;
    end
  end

  always_comb begin
    unique case (cfg.mode)
      EV_LEVEL: event_o = rx_eff;
      EV_RISE:  event_o = rx_eff & ~hist_q;
      EV_BOTH:  event_o = rx_eff ^ hist_q;
      default:  event_o = 1'b0;
    endcase
  end

  always_comb begin
    dw0_rd                 = '0;
    dw0_rd[TX_BIT]         = cfg.tx;
    dw0_rd[RX_BIT]         = rx_sync;
    dw0_rd[INV_BIT]        = cfg.inv;
    dw0_rd[MODE_LO +: 2]   = cfg.mode;
    dw0_rd[RST_LO +: 2]    = cfg.rst_cfg;
  end

  assign dw1_rd = dw1_q;
  assign tx     = cfg.tx;
endmodule

// File: rtl/gpc_bank_irq.sv
module gpc_bank_irq #(
  parameter int unsigned PADS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PADS-1:0] ev,
  input  logic            clr_we,
  input  logic            ena_we,
  input  logic [PADS-1:0] wdata,
  output logic [PADS-1:0] status,
  output logic [PADS-1:0] enable
);
  logic [PADS-1:0] clr_mask;

  assign clr_mask = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      // a fresh event outranks a clear in the same cycle
      status <= (status & ~clr_mask) | ev;
      if (ena_we) enable <= wdata;
    end
  end
endmodule

// File: rtl/gpio_community.sv
module gpio_community
  import gpc_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 2,
  parameter int unsigned PADS_PER_BANK = 8,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned PAD_BASE      = 'h400,
  localparam int unsigned NUM_PADS     = NUM_BANKS * PADS_PER_BANK
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic                irq
);
  localparam int unsigned ENTRY_BASE = PAD_BASE / PAD_STRIDE;
  localparam int unsigned STS_BLK    = STS_OFF >> 5;
  localparam int unsigned ENA_BLK    = ENA_OFF >> 5;

  logic       rd_req, wr_req, aligned;
  logic       ptr_hit, sts_blk_hit, ena_blk_hit;
  logic [1:0] word_sel;
  logic [2:0] bank_sel;

  assign rd_req      = bus_req & ~bus_we;
  assign wr_req      = bus_req & bus_we;
  assign aligned     = (bus_addr[1:0] == 2'b00);
  assign word_sel    = bus_addr[3:2];
  assign bank_sel    = bus_addr[4:2];
  assign ptr_hit     = aligned && (bus_addr == ADDR_W'(PTR_OFF));
  assign sts_blk_hit = aligned && (bus_addr[ADDR_W-1:5] == (ADDR_W-5)'(STS_BLK));
  assign ena_blk_hit = aligned && (bus_addr[ADDR_W-1:5] == (ADDR_W-5)'(ENA_BLK));

  // ---------------- pads ----------------
  logic [NUM_PADS-1:0] rx_sync;
  logic [NUM_PADS-1:0] pad_ev;
  logic [NUM_PADS-1:0] ent_hit;
  logic [31:0]         dw0_rd [NUM_PADS];
  logic [31:0]         dw1_rd [NUM_PADS];

  gpc_sync2 #(.W(NUM_PADS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (rx_sync)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int unsigned ENT = ENTRY_BASE + p;
    assign ent_hit[p] = aligned && (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(ENT));

    gpc_pad_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_dw0  (wr_req && ent_hit[p] && (word_sel == 2'd0)),
      .wr_dw1  (wr_req && ent_hit[p] && (word_sel == 2'd1)),
      .wdata   (bus_wdata),
      .rx_sync (rx_sync[p]),
      .tx      (pad_out[p]),
      .dw0_rd  (dw0_rd[p]),
      .dw1_rd  (dw1_rd[p]),
      .event_o (pad_ev[p])
    );
  end

  // ---------------- banks ----------------
  logic [NUM_PADS-1:0]  sts_flat;
  logic [NUM_PADS-1:0]  ena_flat;
  logic [NUM_BANKS-1:0] sts_hit;
  logic [NUM_BANKS-1:0] ena_hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [2:0] BSEL = 3'(b);
    assign sts_hit[b] = sts_blk_hit && (bank_sel == BSEL);
    assign ena_hit[b] = ena_blk_hit && (bank_sel == BSEL);

    gpc_bank_irq #(.PADS(PADS_PER_BANK)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (pad_ev[b*PADS_PER_BANK +: PADS_PER_BANK]),
      .clr_we (wr_req && sts_hit[b]),
      .ena_we (wr_req && ena_hit[b]),
      .wdata  (bus_wdata[PADS_PER_BANK-1:0]),
      .status (sts_flat[b*PADS_PER_BANK +: PADS_PER_BANK]),
      .enable (ena_flat[b*PADS_PER_BANK +: PADS_PER_BANK])
    );
  end

  assign irq = |(sts_flat & ena_flat);

  // ---------------- read path ----------------
  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (ptr_hit) rd_next = 32'(PAD_BASE);
    for (int p = 0; p < NUM_PADS; p++) begin
      if (ent_hit[p]) begin
        if (word_sel == 2'd0)      rd_next = dw0_rd[p];
        else if (word_sel == 2'd1) rd_next = dw1_rd[p];
      end
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sts_hit[b]) rd_next = 32'(sts_flat[b*PADS_PER_BANK +: PADS_PER_BANK]);
      if (ena_hit[b]) rd_next = 32'(ena_flat[b*PADS_PER_BANK +: PADS_PER_BANK]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/gpc_chk.sv
module gpc_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned PAD_BASE = 'h400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wdata0,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              pad0_out,
  input logic              irq,
  input logic              ena_any
);
  // R14
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);

  // R14
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid);

  // R1
  ptr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr == ADDR_W'('h00C)) |=> (bus_rdata == 32'(PAD_BASE)));

  // R2
  tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == ADDR_W'(PAD_BASE)) |=> (pad0_out == $past(wdata0)));

  // R12
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_any |-> !irq);
endmodule

bind gpio_community gpc_chk #(.ADDR_W(ADDR_W), .PAD_BASE(PAD_BASE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .wdata0     (bus_wdata[0]),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .pad0_out   (pad_out[0]),
  .irq        (irq),
  .ena_any    (|ena_flat)
);

// File: tb/gpio_community_tb.sv
`timescale 1ns/1ps
module gpio_community_tb;
  localparam int NB = 2;
  localparam int PPB = 8;
  localparam int NP = NB * PPB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_community #(.NUM_BANKS(NB), .PADS_PER_BANK(PPB), .ADDR_W(12), .PAD_BASE('h400)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pad_in(pad_in), .pad_out(pad_out), .irq(irq)
  );

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;   // write data, or expected read data
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 12'h430, 32'hC000_0001, 8'd4},  // R4 write
    '{1'b0, 12'h430, 32'hC000_0001, 8'd4},  // R4 readback
    '{1'b1, 12'h430, 32'h0F7F_FFFC, 8'd4},  // R4 write with spare bits
    '{1'b0, 12'h430, 32'h0600_0000, 8'd4},  // R4 spare bits read zero
    '{1'b1, 12'h430, 32'h0000_0000, 8'd4},  // R4 restore
    '{1'b1, 12'h434, 32'hDEAD_BEEF, 8'd5},  // R5
    '{1'b0, 12'h434, 32'hDEAD_BEEF, 8'd5},  // R5
    '{1'b0, 12'h438, 32'h0000_0000, 8'd5},  // R5 +8 zero
    '{1'b0, 12'h00C, 32'h0000_0400, 8'd1},  // R1
    '{1'b1, 12'h00C, 32'hFFFF_FFFF, 8'd1},  // R1 write ignored
    '{1'b0, 12'h00C, 32'h0000_0400, 8'd1},  // R1
    '{1'b1, 12'h010, 32'h1234_5678, 8'd13}, // R13
    '{1'b0, 12'h010, 32'h0000_0000, 8'd13}, // R13
    '{1'b0, 12'h500, 32'h0000_0000, 8'd13}, // R13 past last pad
    '{1'b0, 12'h108, 32'h0000_0000, 8'd13}, // R13 absent bank
    '{1'b0, 12'h432, 32'h0000_0000, 8'd13}, // R13 misaligned
    '{1'b1, 12'h120, 32'hFFFF_FFFF, 8'd12}, // R12
    '{1'b0, 12'h120, 32'h0000_00FF, 8'd12}, // R12 masked width
    '{1'b1, 12'h120, 32'h0000_0000, 8'd12}, // R12
    '{1'b0, 12'h120, 32'h0000_0000, 8'd12}, // R12
    '{1'b0, 12'h100, 32'h0000_0000, 8'd11}  // R11 no events yet
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic do_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    check("R14", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    check("R2", 32'(pad_out), 32'd0);
    check("R12", 32'(irq), 32'd0);
    check("R14", 32'(bus_rvalid), 32'd0);
    rst_n = 1'b1;
    idle(2);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].we) do_write(TBL[i].addr, TBL[i].data);
      else begin
        do_read(TBL[i].addr, d);
        n_vec++;
        if (d !== TBL[i].data) begin
          n_bad++;
          $display("FAIL R%0d actual=%08h expected=%08h", TBL[i].req, d, TBL[i].data);
        end
      end
    end

    // R2 drive value
    do_write(12'h420, 32'h1);
    check("R2", 32'(pad_out), 32'h0004);

    // R3 synchroniser latency and write-ignore
    @(negedge clk); pad_in[5] = 1'b1;
    do_read(12'h450, d);
    check("R3", 32'(d[1]), 32'd0);
    do_read(12'h450, d);
    check("R3", 32'(d[1]), 32'd1);
    do_write(12'h460, 32'h2);
    do_read(12'h460, d);
    check("R3", d, 32'h0);

    // R6 level mode on pad 9 (bank 1 bit 1)
    @(negedge clk); pad_in[9] = 1'b1;
    idle(4);
    do_read(12'h104, d); check("R6", d, 32'h02);
    do_write(12'h104, 32'h02);
    do_read(12'h104, d); check("R6", d, 32'h02);
    @(negedge clk); pad_in[9] = 1'b0;
    idle(4);
    do_write(12'h104, 32'h02);
    do_read(12'h104, d); check("R6", d, 32'h00);

    // R7 rising edge on pad 10 (bit 2)
    do_write(12'h4A0, 32'h0200_0000);
    @(negedge clk); pad_in[10] = 1'b1;
    idle(4);
    do_read(12'h104, d); check("R7", d, 32'h04);
    do_write(12'h104, 32'h04);
    do_read(12'h104, d); check("R7", d, 32'h00);
    @(negedge clk); pad_in[10] = 1'b0;
    idle(4);
    do_read(12'h104, d); check("R7", d, 32'h00);

    // R8 both edges on pad 11 (bit 3), falling edge meets a clear (R11)
    do_write(12'h4B0, 32'h0600_0000);
    @(negedge clk); pad_in[11] = 1'b1;
    idle(4);
    do_read(12'h104, d); check("R8", d, 32'h08);
    @(negedge clk); pad_in[11] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h104; bus_wdata = 32'h08;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    do_read(12'h104, d); check("R11", d, 32'h08);
    do_write(12'h104, 32'h08);
    do_read(12'h104, d); check("R11", d, 32'h00);

    // R9 events disabled on pad 12 (bit 4)
    do_write(12'h4C0, 32'h0400_0000);
    @(negedge clk); pad_in[12] = 1'b1;
    idle(4);
    @(negedge clk); pad_in[12] = 1'b0;
    idle(4);
    do_read(12'h104, d); check("R9", d, 32'h00);

    // R10 inversion on pad 13 (bit 5)
    do_write(12'h4D0, 32'h0400_0000);
    @(negedge clk); pad_in[13] = 1'b1;
    idle(4);
    do_write(12'h4D0, 32'h0280_0000);
    idle(4);
    do_read(12'h104, d); check("R10", d, 32'h00);
    @(negedge clk); pad_in[13] = 1'b0;
    idle(4);
    do_read(12'h104, d); check("R10", d, 32'h20);
    do_write(12'h104, 32'h20);

    // R12 irq timing and gating on pad 14 (bit 6)
    do_write(12'h4E0, 32'h0200_0000);
    do_write(12'h124, 32'h40);
    @(negedge clk); pad_in[14] = 1'b1;
    @(negedge clk);
    @(negedge clk); check("R12", 32'(irq), 32'd0);
    @(negedge clk); check("R12", 32'(irq), 32'd1);
    do_write(12'h124, 32'h0);
    check("R12", 32'(irq), 32'd0);
    do_read(12'h104, d); check("R12", d, 32'h40);
    do_write(12'h124, 32'h40);
    check("R12", 32'(irq), 32'd1);
    do_write(12'h104, 32'h40);
    check("R11", 32'(irq), 32'd0);

    done = 1'b1;
    finish_run();
  end
endmodule